// File: doc/BRIEF.md
# Multi-Slot Interrupt Aggregator

This block gathers interrupt requests from a set of peripheral slots, each slot driving two request lines, together with a one-cycle bus-error pulse per slot. It folds them into a single host interrupt. Software reaches the block through a small address/data register port. Through that port it sets a per-line enable mask, a global enable, a debug force bit and a bus-error interrupt enable. It also reads back a status word that shows every pending source, whether or not that source is masked.

Bus errors are remembered per slot until software issues a single clear. That clear wipes the error flags of every slot at once and returns the bus-error interrupt state machine to idle. The global enable gates every source, including the force bit, so with it cleared the host line stays low whatever else is pending.

Top module: `intagg_top`

## Requirements
- R1: `host_irq` is 0 in every cycle in which the global enable (control register, address 0, bit 0) is 0.
- R2: With the global enable set, setting the force bit (address 0, bit 1) drives `host_irq` to 1 with no request line active. With the global enable clear, the force bit has no effect on `host_irq`.
- R3: `host_irq` is the global enable ANDed with the OR of three terms: any enabled pending line, the force bit, and the bus-error state machine being in its pending state. Line `l` of slot `s` uses status and mask bit `2*s+l`, and the mask sits at address 1.
- R4: The status register (address 2, read only) shows the sampled request lines in bits [9:0], one clock after the inputs, whatever the mask holds. A status bit clears once its slot drops the request.
- R5: A one-cycle `err_pulse[s]` sets status bit `10+s`, and that bit stays set until a clear.
- R6: Writing 1 to bit 2 of address 0 clears all bus-error status bits and returns the bus-error state machine to idle at that write's clock edge. An error pulse arriving in the same cycle as the clear is still recorded.
- R7: Bit 2 of address 0 always reads back as 0.
- R8: The bus-error state machine enters its pending state once any bus-error status bit is set while the bus-error interrupt enable (address 0, bit 3) is 1. It stays pending until a clear.
- R9: After reset, the control and mask registers and all status bits read 0 and `host_irq` is 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq_in | input | 10 | Slot request lines, bit 2*s+l |
| err_pulse | input | 5 | Per-slot bus-error pulse |
| host_irq | output | 1 | Aggregated host interrupt |

## Verification
The bench builds the block with its defaults: five slots with two lines each, a 2-bit address and 32-bit data. This puts the last line at mask and status bit 9 and the last error flag at bit 14, so the vector table reaches the slot-4 edge of both fields. A table of mask, control and request patterns covers gating, masking and forcing. Directed tests then cover sticky error flags, the clear racing a new pulse, the error state machine, and level-following release.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_MASK = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;

    localparam int B_ME    = 0;
    localparam int B_FORCE = 1;
    localparam int B_CLR   = 2;
    localparam int B_ERRIE = 3;

    typedef enum logic {
        ERR_IDLE = 1'b0,
        ERR_PEND = 1'b1
    } err_state_e;
endpackage

// File: rtl/intagg_regs.sv
module intagg_regs
    import intagg_pkg::*;
#(
    parameter int NUM_SRC = 10,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic               me_o,
    output logic               frc_o,
    output logic               eie_o,
    output logic               clr_o,
    output logic [NUM_SRC-1:0] mask_o
);
    typedef struct packed {
        logic               me;
        logic               frc;
        logic               eie;
        logic [NUM_SRC-1:0] mask;
    } regs_t;

    regs_t r_d, r_q;
    logic  ctrl_wr, mask_wr;

    always_comb begin
        ctrl_wr = wr_en && (addr == ADDR_W'(A_CTRL));
        mask_wr = wr_en && (addr == ADDR_W'(A_MASK));
        r_d     = r_q;
        if (ctrl_wr) begin
            r_d.me  = wdata[B_ME];
            r_d.frc = wdata[B_FORCE];
            r_d.eie = wdata[B_ERRIE];
        end
        if (mask_wr) begin
            r_d.mask = wdata[NUM_SRC-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign me_o   = r_q.me;
    assign frc_o  = r_q.frc;
    assign eie_o  = r_q.eie;
    assign mask_o = r_q.mask;
    assign clr_o  = ctrl_wr && wdata[B_CLR];
endmodule

// File: rtl/intagg_lines.sv
module intagg_lines #(
    parameter int NUM_SLOTS = 5,
    parameter int LINES     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SLOTS*LINES-1:0]  irq_in,
    input  logic [NUM_SLOTS*LINES-1:0]  mask,
    output logic [NUM_SLOTS*LINES-1:0]  irq_sts,
    output logic                        hit
);
    localparam int NUM_SRC = NUM_SLOTS * LINES;

    typedef struct packed {
        logic [NUM_SRC-1:0] sts;
    } line_t;

    line_t l_d, l_q;
    logic [NUM_SLOTS-1:0] slot_hit;

    always_comb begin
        l_d     = l_q;
        l_d.sts = irq_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign slot_hit[s] = |(l_q.sts[s*LINES +: LINES] & mask[s*LINES +: LINES]);
    end

    assign irq_sts = l_q.sts;
    assign hit     = |slot_hit;
endmodule

// File: rtl/intagg_err.sv
module intagg_err
    import intagg_pkg::*;
#(
    parameter int NUM_SLOTS = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] err_pulse,
    input  logic                 clr,
    input  logic                 eie,
    output logic [NUM_SLOTS-1:0] err_sts,
    output logic                 err_active
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0] sts;
        err_state_e           st;
    } err_t;

    err_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        // clear first, new pulses afterwards so none is lost
        if (clr) e_d.sts = '0;
        e_d.sts = e_d.sts | err_pulse;
        unique case (e_q.st)
            ERR_IDLE: if (eie && (|e_q.sts) && !clr) e_d.st = ERR_PEND;
            ERR_PEND: if (clr) e_d.st = ERR_IDLE;
            default:  e_d.st = ERR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{sts: '0, st: ERR_IDLE};
        else        e_q <= e_d;
    end

    assign err_sts    = e_q.sts;
    assign err_active = (e_q.st == ERR_PEND);
endmodule

// File: rtl/intagg_top.sv
module intagg_top
    import intagg_pkg::*;
#(
    parameter int NUM_SLOTS = 5,
    parameter int LINES     = 2,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rd_data,
    input  logic [NUM_SLOTS*LINES-1:0] irq_in,
    input  logic [NUM_SLOTS-1:0]       err_pulse,
    output logic                       host_irq
);
    localparam int NUM_SRC = NUM_SLOTS * LINES;

    logic               me, frc, eie, clr, hit, err_active;
    logic [NUM_SRC-1:0] mask, irq_sts;
    logic [NUM_SLOTS-1:0] err_sts;

    intagg_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .me_o(me), .frc_o(frc), .eie_o(eie), .clr_o(clr), .mask_o(mask)
    );

    intagg_lines #(.NUM_SLOTS(NUM_SLOTS), .LINES(LINES)) i_lines (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask(mask),
        .irq_sts(irq_sts), .hit(hit)
    );

    intagg_err #(.NUM_SLOTS(NUM_SLOTS)) i_err (
        .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .clr(clr), .eie(eie),
        .err_sts(err_sts), .err_active(err_active)
    );

    always_comb begin
        rd_data = '0;
        unique case (addr)
            ADDR_W'(A_CTRL): begin
                rd_data[B_ME]    = me;
                rd_data[B_FORCE] = frc;
                rd_data[B_ERRIE] = eie;
            end
            ADDR_W'(A_MASK): rd_data[NUM_SRC-1:0] = mask;
            ADDR_W'(A_STAT): begin
                rd_data[NUM_SRC-1:0]           = irq_sts;
                rd_data[NUM_SRC +: NUM_SLOTS]  = err_sts;
            end
            default: rd_data = '0;
        endcase
    end

    assign host_irq = me && (hit || frc || err_active);
endmodule

// File: rtl/intagg_chk.sv
module intagg_chk
    import intagg_pkg::*;
#(
    parameter int NUM_SLOTS = 5,
    parameter int LINES     = 2,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       host_irq,
    input logic                       me,
    input logic                       frc,
    input logic                       clr,
    input logic                       err_active,
    input logic [NUM_SLOTS-1:0]       err_pulse,
    input logic [NUM_SLOTS-1:0]       err_sts,
    input logic [NUM_SLOTS*LINES-1:0] irq_in,
    input logic [NUM_SLOTS*LINES-1:0] irq_sts,
    input logic [ADDR_W-1:0]          addr,
    input logic [DATA_W-1:0]          rd_data
);
    // R1
    host_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !me |-> !host_irq);

    // R2
    force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (me && frc) |-> host_irq);

    // R4
    level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_sts == $past(irq_in)));

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((err_sts & $past(err_sts)) == $past(err_sts)));

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (err_pulse == '0)) |=> ((err_sts == '0) && !err_active));

    // R7
    clr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(A_CTRL)) |-> !rd_data[B_CLR]);

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_active && !clr) |=> err_active);
endmodule

bind intagg_top intagg_chk #(
    .NUM_SLOTS(NUM_SLOTS), .LINES(LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .host_irq(host_irq), .me(me), .frc(frc),
    .clr(clr), .err_active(err_active), .err_pulse(err_pulse),
    .err_sts(err_sts), .irq_in(irq_in), .irq_sts(irq_sts),
    .addr(addr), .rd_data(rd_data)
);

// File: tb/test_intagg_top.sv
module test_intagg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic [9:0]  irq_in = '0;
    logic [4:0]  err_pulse = '0;
    logic        host_irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    intagg_top i_intagg_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .irq_in(irq_in), .err_pulse(err_pulse),
        .host_irq(host_irq)
    );

    // {ctrl[3:0], mask[9:0], irq[9:0], expected host_irq}
    localparam logic [24:0] VEC [0:8] = '{
        {4'h0, 10'h3FF, 10'h3FF, 1'b0},  // R1 gated off
        {4'h1, 10'h000, 10'h3FF, 1'b0},  // R4 all masked
        {4'h1, 10'h001, 10'h001, 1'b1},  // R3 slot0 line0
        {4'h1, 10'h002, 10'h001, 1'b0},  // R3 other line
        {4'h1, 10'h200, 10'h200, 1'b1},  // R3 slot4 line1
        {4'h3, 10'h000, 10'h000, 1'b1},  // R2 force
        {4'h2, 10'h3FF, 10'h3FF, 1'b0},  // R2 force without enable
        {4'h1, 10'h155, 10'h2AA, 1'b0},  // R3 disjoint
        {4'h1, 10'h155, 10'h2AB, 1'b1}   // R3 overlap bit 0
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        rd(2'd0, v); check("R9 ctrl", v, 32'h0);
        rd(2'd1, v); check("R9 mask", v, 32'h0);
        rd(2'd2, v); check("R9 status", v, 32'h0);
        rd(2'd3, v); check("R9 addr3", v, 32'h0);
        check("R9 host_irq", {31'b0, host_irq}, 32'h0);

        for (int i = 0; i < 9; i++) begin
            wr(2'd0, {28'b0, VEC[i][24:21]});
            wr(2'd1, {22'b0, VEC[i][20:11]});
            irq_in = VEC[i][10:1];
            @(negedge clk);
            check($sformatf("R3 vec%0d host_irq", i), {31'b0, host_irq}, {31'b0, VEC[i][0]});
            rd(2'd2, v);
            check($sformatf("R4 vec%0d status", i), v, {22'b0, VEC[i][10:1]});
        end

        // R4 level-following release
        irq_in = '0;
        @(negedge clk);
        rd(2'd2, v); check("R4 release", v, 32'h0);
        rd(2'd1, v); check("R3 mask readback", v, 32'h155);

        // R5 sticky error, error enable off so FSM idle
        wr(2'd0, 32'h1);
        wr(2'd1, 32'h0);
        @(negedge clk); err_pulse = 5'b00100;
        @(negedge clk); err_pulse = '0;
        repeat (3) @(negedge clk);
        rd(2'd2, v); check("R5 sticky slot2", v, 32'h1 << 12);
        check("R8 no irq without enable", {31'b0, host_irq}, 32'h0);

        // R8 enable error interrupt
        wr(2'd0, 32'h9);
        @(negedge clk);
        check("R8 pending", {31'b0, host_irq}, 32'h1);
        wr(2'd0, 32'h1);
        check("R8 holds past enable drop", {31'b0, host_irq}, 32'h1);

        // R6 clear resets flags and FSM, R7 readback
        wr(2'd0, 32'hD);
        rd(2'd2, v); check("R6 cleared", v, 32'h0);
        check("R6 fsm idle", {31'b0, host_irq}, 32'h0);
        rd(2'd0, v); check("R7 clear reads 0", v, 32'h9);

        // R6 pulse in same cycle as clear is kept
        @(negedge clk); err_pulse = 5'b10000;
        wr_en = 1'b1; addr = 2'd0; wdata = 32'hD;
        @(negedge clk); err_pulse = '0; wr_en = 1'b0; wdata = '0;
        rd(2'd2, v); check("R6 race kept slot4", v, 32'h1 << 14);
        @(negedge clk);
        check("R8 race re-arms", {31'b0, host_irq}, 32'h1);

        // R1 master off hides error interrupt
        wr(2'd0, 32'h8);
        check("R1 gated error", {31'b0, host_irq}, 32'h0);

        finish_run();
    end
endmodule